// File: doc/BRIEF.md
# SDRAM Mode Register Command Decoder

This block sits beside a DDR SDRAM command bus and samples it on every rising clock edge. When it sees a mode write (chip select, row strobe, column strobe and write enable all low together), it checks that the write is legal and, if it is, captures the mode word. Bank address bit 0 selects the target: low for the main mode register, whose fields are decoded, and high for the extended register, whose word is only stored.

A main-register write is legal only when all banks are idle and CKE is high. The reserved upper bits and the test bit must be zero, and the burst-length and latency codes must be defined ones. A rejected write leaves every register unchanged and pulses the error flag. An accepted write holds a busy flag for two cycles, and any command that arrives during that window is flagged and ignored. The decoded burst length, burst order and read latency (as a half-cycle count) are meant for a controller's timing logic. A valid flag shows when they can be trusted.

Top module: `sdram_mode_decoder`

## Requirements
- R1: A main mode write is recognised when cs_n, ras_n, cas_n and we_n are all low and ba[0] is 0. Once accepted, mode_valid is high from the cycle after the sampling edge, and the decoded outputs show the new word in that same cycle.
- R2: Word bits 2:0 give the burst length: code 1 gives burst_len 2, code 2 gives 4 and code 3 gives 8. Bit 3 drives burst_interleave (0 sequential, 1 interleaved).
- R3: Word bits 6:4 give the read latency as cas_half in half cycles: code 3 gives 6 and code 6 gives 5.
- R4: A main write with any other burst-length code or latency code is rejected and raises mode_err.
- R5: A main write with bit 7 set, any of bits 11:9 set, or ba[1] set is rejected and raises mode_err.
- R6: A mode write (main or extended) with banks_idle low or cke low is rejected, raises mode_err and changes no output register.
- R7: An accepted write drives busy high for exactly two cycles. Any command issued while busy (cs_n low and not ras_n, cas_n and we_n all high) raises mode_err and is ignored.
- R8: A mode write with ba[0] set to 1 loads the 12-bit word into ext_mode without checking its fields and leaves the main decoded outputs unchanged.
- R9: An accepted main write with bit 8 set produces a one-cycle pulse on dll_reset_pulse.
- R10: Synchronous active-low reset clears mode_valid, busy, mode_err, dll_reset_pulse, ext_mode and the decoded outputs. mode_valid stays low until the first accepted main write, and the register may be rewritten later under the same rules.
- R11: mode_err is a one-cycle pulse in the cycle after the offending command's sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address; bit 0 selects the register, bit 1 is reserved |
| addr | input | 12 | Mode word on the address bus |
| cke | input | 1 | Clock enable level |
| banks_idle | input | 1 | All banks precharged and idle |
| burst_len | output | 4 | Decoded burst length (2, 4, 8; 0 before the first write) |
| burst_interleave | output | 1 | Burst order, 1 for interleaved |
| cas_half | output | 4 | Read latency in half cycles |
| mode_valid | output | 1 | Main register holds an accepted word |
| ext_mode | output | 12 | Last accepted extended word |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| mode_err | output | 1 | One-cycle error pulse |
| busy | output | 1 | Mode write in progress |

## Verification
The assertions assume the command pins, bank address, CKE and idle status are settled and known at every rising edge after reset. They also assume the bus is driven only by the stimulus, with no other agent issuing commands. The bench changes every input on the falling edge and returns the bus to a NOP after each command. Before each table entry it waits until busy has cleared, so that only the directed busy test issues a command inside the window.

// File: rtl/mrs_pkg.sv
// Shared types for the mode register decoder.
// Assumes a 12-bit mode word with fields at fixed positions.
package mrs_pkg;
    localparam int MODE_W = 12;

    typedef struct packed {
        logic [3:0] burst_len;
        logic       interleave;
        logic [3:0] cas_half;
    } mode_fields_t;
endpackage

// File: rtl/mrs_cmd_decode.sv
// Classifies the command pins for one cycle.
// Assumes active-low pins; a NOP is cs low with ras, cas and we high.
module mrs_cmd_decode (
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic bank_sel,
    output logic load_main,
    output logic load_ext,
    output logic any_cmd
);
    logic mode_cmd;

    // Decode mode write and any non-NOP command.
    always_comb begin
        mode_cmd  = !cs_n && !ras_n && !cas_n && !we_n;
        load_main = mode_cmd && !bank_sel;
        load_ext  = mode_cmd && bank_sel;
        any_cmd   = !cs_n && !(ras_n && cas_n && we_n);
    end
endmodule

// File: rtl/mrs_field_check.sv
// Decodes the main mode word and judges its legality.
// Assumes bits 2:0 burst length, 3 order, 6:4 latency, 7 test, 8 DLL,
// and that every bit from 9 upward is reserved.
module mrs_field_check #(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0]         word,
    input  logic                      bank_hi,
    output mrs_pkg::mode_fields_t     fields,
    output logic                      dll_req,
    output logic                      legal
);
    localparam int RSV_LSB = 9;

    logic bl_ok, cl_ok, rsv_ok;

    // Map burst-length and latency codes, flag undefined codes.
    always_comb begin
        fields.interleave = word[3];
        dll_req           = word[8];
        case (word[2:0])
            3'd1:    begin fields.burst_len = 4'd2; bl_ok = 1'b1; end
            3'd2:    begin fields.burst_len = 4'd4; bl_ok = 1'b1; end
            3'd3:    begin fields.burst_len = 4'd8; bl_ok = 1'b1; end
            default: begin fields.burst_len = 4'd0; bl_ok = 1'b0; end
        endcase
        case (word[6:4])
            3'd3:    begin fields.cas_half = 4'd6; cl_ok = 1'b1; end
            3'd6:    begin fields.cas_half = 4'd5; cl_ok = 1'b1; end
            default: begin fields.cas_half = 4'd0; cl_ok = 1'b0; end
        endcase
        rsv_ok = !word[7] && (word[WORD_W-1:RSV_LSB] == '0) && !bank_hi;
        legal  = bl_ok && cl_ok && rsv_ok;
    end
endmodule

// File: rtl/mrs_busy_timer.sv
// Holds busy for a fixed number of cycles after a start pulse.
// Assumes start is never raised while busy.
module mrs_busy_timer #(
    parameter int HOLD_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] remain_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (start)
            remain_q <= CNT_W'(HOLD_CYCLES);
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign busy = (remain_q != '0);
endmodule

// File: rtl/sdram_mode_decoder.sv
// Watches the command bus, validates mode writes and keeps the decoded
// mode. Assumes inputs are synchronous to clk; rejected writes change nothing.
module sdram_mode_decoder #(
    parameter int WORD_W      = mrs_pkg::MODE_W,
    parameter int HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [WORD_W-1:0] addr,
    input  logic              cke,
    input  logic              banks_idle,
    output logic [3:0]        burst_len,
    output logic              burst_interleave,
    output logic [3:0]        cas_half,
    output logic              mode_valid,
    output logic [WORD_W-1:0] ext_mode,
    output logic              dll_reset_pulse,
    output logic              mode_err,
    output logic              busy
);
    import mrs_pkg::*;

    logic         load_main, load_ext, any_cmd;
    logic         legal, dll_req, allowed;
    logic         take_main, take_ext, err_d;
    mode_fields_t fields_new, fields_q;
    logic         valid_q, err_q, dll_q;
    logic [WORD_W-1:0] ext_q;

    mrs_cmd_decode u_cmd (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_sel(ba[0]), .load_main(load_main), .load_ext(load_ext),
        .any_cmd(any_cmd)
    );

    mrs_field_check #(.WORD_W(WORD_W)) u_fields (
        .word(addr), .bank_hi(ba[1]), .fields(fields_new),
        .dll_req(dll_req), .legal(legal)
    );

    mrs_busy_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(take_main || take_ext), .busy(busy)
    );

    // Decide acceptance and error for the sampled command.
    always_comb begin
        allowed   = banks_idle && cke && !busy;
        take_main = load_main && allowed && legal;
        take_ext  = load_ext && allowed;
        err_d     = (busy && any_cmd)
                  || (load_main && !(allowed && legal))
                  || (load_ext && !allowed);
    end

    // Store accepted words and register the pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= '0;
            valid_q  <= 1'b0;
            ext_q    <= '0;
            err_q    <= 1'b0;
            dll_q    <= 1'b0;
        end else begin
            if (take_main) begin
                fields_q <= fields_new;
                valid_q  <= 1'b1;
            end
            if (take_ext)
                ext_q <= addr;
            err_q <= err_d;
            dll_q <= take_main && dll_req;
        end
    end

    assign burst_len        = fields_q.burst_len;
    assign burst_interleave = fields_q.interleave;
    assign cas_half         = fields_q.cas_half;
    assign mode_valid       = valid_q;
    assign ext_mode         = ext_q;
    assign mode_err         = err_q;
    assign dll_reset_pulse  = dll_q;
endmodule

// File: rtl/mrs_decoder_checker.sv
// Temporal properties of the mode decoder, attached by bind.
// Assumes inputs are known at every rising edge after reset.
module mrs_decoder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic        cke,
    input logic        banks_idle,
    input logic [3:0]  burst_len,
    input logic [3:0]  cas_half,
    input logic        mode_valid,
    input logic        dll_reset_pulse,
    input logic        mode_err,
    input logic        busy
);
    logic mode_pins;
    assign mode_pins = !cs_n && !ras_n && !cas_n && !we_n;

    assert_legal_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> ((burst_len == 4'd2 || burst_len == 4'd4 || burst_len == 4'd8)
                        && (cas_half == 4'd5 || cas_half == 4'd6)));

    assert_cke_low_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pins && !cke) |=> mode_err);

    assert_not_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_pins && !banks_idle) |=> ($stable(burst_len) && $stable(cas_half)));

    assert_busy_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    assert_dll_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_pulse |=> !dll_reset_pulse);

    assert_dll_with_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset_pulse |-> (busy && mode_valid));
endmodule

bind sdram_mode_decoder mrs_decoder_checker chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .banks_idle(banks_idle), .burst_len(burst_len),
    .cas_half(cas_half), .mode_valid(mode_valid),
    .dll_reset_pulse(dll_reset_pulse), .mode_err(mode_err), .busy(busy)
);

// File: tb/sdram_mode_decoder_tb_top.sv
`timescale 1ns/1ps
module sdram_mode_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n, cke, banks_idle;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [3:0]  burst_len, cas_half;
    logic        burst_interleave, mode_valid, dll_reset_pulse, mode_err, busy;
    logic [11:0] ext_mode;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdram_mode_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cke(cke), .banks_idle(banks_idle),
        .burst_len(burst_len), .burst_interleave(burst_interleave),
        .cas_half(cas_half), .mode_valid(mode_valid), .ext_mode(ext_mode),
        .dll_reset_pulse(dll_reset_pulse), .mode_err(mode_err), .busy(busy)
    );

    typedef struct packed {
        logic [1:0]  ba;
        logic [11:0] word;
        logic        idle;
        logic        cke;
        logic        err;
        logic [3:0]  bl;
        logic        il;
        logic [3:0]  cl;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 12'h031, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0, 4'd6}, // R1 R2 R3
        '{2'b00, 12'h06B, 1'b1, 1'b1, 1'b0, 4'd8, 1'b1, 4'd5}, // R2 R3
        '{2'b00, 12'h032, 1'b1, 1'b1, 1'b0, 4'd4, 1'b0, 4'd6}, // R2
        '{2'b00, 12'h030, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R4 bl 0
        '{2'b00, 12'h034, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R4 bl 4
        '{2'b00, 12'h022, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R4 cl 2
        '{2'b00, 12'h072, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R4 cl 7
        '{2'b00, 12'h0B2, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R5 bit 7
        '{2'b00, 12'h232, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R5 bit 9
        '{2'b10, 12'h032, 1'b1, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R5 ba1
        '{2'b00, 12'h06B, 1'b0, 1'b1, 1'b1, 4'd4, 1'b0, 4'd6}, // R6 not idle
        '{2'b00, 12'h06B, 1'b1, 1'b0, 1'b1, 4'd4, 1'b0, 4'd6}, // R6 cke low
        '{2'b00, 12'h06A, 1'b1, 1'b1, 1'b0, 4'd4, 1'b1, 4'd5}  // R10 rewrite
    };

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic nop();
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        ba = 2'b00; addr = '0; cke = 1'b1; banks_idle = 1'b1;
    endtask

    // Drive a mode write at a falling edge, return at the next falling edge.
    task automatic mode_write(input logic [1:0] b, input logic [11:0] w,
                              input logic idle, input logic ck);
        cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
        ba = b; addr = w; banks_idle = idle; cke = ck;
        @(negedge clk);
        nop();
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        nop();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 mode_valid", mode_valid, 0);
        chk("R10 busy", busy, 0);
        chk("R10 mode_err", mode_err, 0);
        chk("R10 ext_mode", ext_mode, 0);
        chk("R10 dll", dll_reset_pulse, 0);

        // R10 rejected write before first valid write keeps valid low
        mode_write(2'b00, 12'h030, 1'b1, 1'b1);
        chk("R4 err before first", mode_err, 1);
        chk("R10 valid stays low", mode_valid, 0);
        @(negedge clk);
        chk("R11 err one cycle", mode_err, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            settle();
            mode_write(VECS[i].ba, VECS[i].word, VECS[i].idle, VECS[i].cke);
            chk($sformatf("R11 vec%0d err", i), mode_err, VECS[i].err);
            chk($sformatf("R2 vec%0d burst_len", i), burst_len, VECS[i].bl);
            chk($sformatf("R2 vec%0d interleave", i), burst_interleave, VECS[i].il);
            chk($sformatf("R3 vec%0d cas_half", i), cas_half, VECS[i].cl);
            chk($sformatf("R1 vec%0d mode_valid", i), mode_valid, 1);
            chk($sformatf("R7 vec%0d busy", i), busy, VECS[i].err ? 0 : 1);
        end

        // R7 busy window and command during busy
        settle();
        mode_write(2'b00, 12'h031, 1'b1, 1'b1);
        chk("R7 busy cycle1", busy, 1);
        chk("R1 accepted bl", burst_len, 2);
        mode_write(2'b00, 12'h06B, 1'b1, 1'b1);
        chk("R7 err while busy", mode_err, 1);
        chk("R7 busy cycle2", busy, 1);
        chk("R7 ignored bl", burst_len, 2);
        chk("R7 ignored cl", cas_half, 6);
        @(negedge clk);
        chk("R7 busy ends", busy, 0);
        chk("R11 err cleared", mode_err, 0);

        // R8 extended write
        settle();
        mode_write(2'b01, 12'hABC, 1'b1, 1'b1);
        chk("R8 ext_mode", ext_mode, 12'hABC);
        chk("R8 err", mode_err, 0);
        chk("R8 main bl kept", burst_len, 2);
        chk("R8 main cl kept", cas_half, 6);
        chk("R8 busy", busy, 1);
        settle();
        mode_write(2'b01, 12'h123, 1'b0, 1'b1);
        chk("R6 ext not idle err", mode_err, 1);
        chk("R6 ext kept", ext_mode, 12'hABC);

        // R9 DLL reset pulse
        settle();
        mode_write(2'b00, 12'h16B, 1'b1, 1'b1);
        chk("R9 pulse high", dll_reset_pulse, 1);
        chk("R9 bl", burst_len, 8);
        @(negedge clk);
        chk("R9 pulse low", dll_reset_pulse, 0);
        settle();
        mode_write(2'b00, 12'h1B2, 1'b1, 1'b1);
        chk("R9 no pulse on reject", dll_reset_pulse, 0);
        chk("R5 err", mode_err, 1);

        // R10 reset clears an active state
        settle();
        mode_write(2'b00, 12'h031, 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 valid cleared", mode_valid, 0);
        chk("R10 busy cleared", busy, 0);
        chk("R10 ext cleared", ext_mode, 0);

        finish_run();
    end
endmodule